// File: doc/BRIEF.md
# Register-Controlled Single-Channel PWM Timer

This block generates one pulse-width-modulated output. A CPU sets it up through two 32-bit registers on a simple write/read port. The control word holds a run enable, a staging (sync) bit and a power-of-two prescale exponent. The count word holds a 10-bit period length and a 10-bit high-phase length. Both lengths are counted in prescaled ticks. The output is high at the start of each period and low for the rest of it (normal polarity only).

New settings take effect only at a period boundary, so no period ever mixes old and new values. While the sync bit is set, the active settings are frozen. Software can then rewrite the period, the phase and the exponent one at a time. The new set starts together at the first period boundary after sync is cleared. The channel does not run while either count is zero, so a 0% duty cycle cannot be produced.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset both registers read zero and the output is low.
- R2: The control word is at byte address 0x0. It has enable at bit 0, sync at bit 11, the exponent's low bit at bit 15 and the exponent's upper four bits at bits 19:16. Reads return the last value written, and all other bits read zero.
- R3: The count word is at byte address 0x4. It has the period count at bits 25:16 and the phase count at bits 9:0. Reads return the last value written, and all other bits read zero.
- R4: The prescale exponent e is {bits 19:16, bit 15}. The counter advances once every 2^e input clocks. Values above 24 act as 24.
- R5: While running, each period lasts period*2^e clocks. The output is high for the first phase*2^e clocks of each period and low for the rest.
- R6: When the phase count is greater than or equal to the period count, the output stays high continuously.
- R7: When the period count or the phase count is zero, the channel does not run and the output stays low, even with enable set.
- R8: Clearing enable drives the output low from the second clock edge after the write. Setting it again starts a fresh period, whose high phase begins on the second clock edge after the write.
- R9: While sync is 1, the running channel keeps its active period, phase and exponent, although register reads already return the new values. The written values take effect together at the first period boundary after sync returns to 0.
- R10: Writes to any other address are ignored, and such addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 4 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM output, normal polarity |

## Verification
The assertions check on every cycle that:
- the output is low one cycle after enable is low or a count is zero;
- the output rises only at the start of a period;
- the period position stays below the active period;
- the active settings do not move while sync is set during a run;
- reserved control bits read zero.

The exact high and low lengths for given exponents, the moment staged values take over after sync is cleared, the continuously high case and the fresh start after re-enable can only be shown by the bench. It measures the output waveform for random and directed settings.

// File: rtl/pwm_timer_pkg.sv
// Package: shared constants and the configuration type for the PWM timer.
// Assumes 32-bit register words and byte addressing.
package pwm_timer_pkg;
    localparam int CNT_W    = 10;
    localparam int CLKF_W   = 4;
    localparam int EXP_W    = CLKF_W + 1;
    localparam int MAX_EXP  = 24;
    localparam int CTRL_OFF = 0;
    localparam int CNT_OFF  = 4;
    localparam int EN_BIT   = 0;
    localparam int SYNC_BIT = 11;
    localparam int MODE_BIT = 15;
    localparam int CLKF_LSB = 16;
    localparam int PER_LSB  = 16;
    localparam int PH_LSB   = 0;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] phase;
        logic [EXP_W-1:0] expo;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_timer_regs.sv
// Module: register file. Holds the programmed control and count fields,
// serves reads and derives the registered run qualifier.
// Assumes DATA_W >= 26 so every field fits in the word.
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en_o,
    output logic              sync_o,
    output logic              run_o,
    output pwm_cfg_t          cfg_o
);
    logic              en_q, sync_q, mode_q, run_q;
    logic [CLKF_W-1:0] clkf_q;
    logic [CNT_W-1:0]  per_q, ph_q;
    logic              sel_ctrl, sel_cnt;

    assign sel_ctrl = (addr == ADDR_W'(CTRL_OFF));
    assign sel_cnt  = (addr == ADDR_W'(CNT_OFF));

    // Capture written fields; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sync_q <= 1'b0;
            mode_q <= 1'b0;
            clkf_q <= '0;
            per_q  <= '0;
            ph_q   <= '0;
        end else begin
            if (wr_en && sel_ctrl) begin
                en_q   <= wdata[EN_BIT];
                sync_q <= wdata[SYNC_BIT];
                mode_q <= wdata[MODE_BIT];
                clkf_q <= wdata[CLKF_LSB +: CLKF_W];
            end
            if (wr_en && sel_cnt) begin
                per_q <= wdata[PER_LSB +: CNT_W];
                ph_q  <= wdata[PH_LSB +: CNT_W];
            end
        end
    end

    // Run only when enabled and both counts are legal (non-zero).
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en_q && (per_q != '0) && (ph_q != '0);
    end

    // Read mux: programmed values, zeros elsewhere.
    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[EN_BIT]                = en_q;
            rdata[SYNC_BIT]              = sync_q;
            rdata[MODE_BIT]              = mode_q;
            rdata[CLKF_LSB +: CLKF_W]    = clkf_q;
        end else if (sel_cnt) begin
            rdata[PER_LSB +: CNT_W]      = per_q;
            rdata[PH_LSB +: CNT_W]       = ph_q;
        end
    end

    assign en_o   = en_q;
    assign sync_o = sync_q;
    assign run_o  = run_q;
    assign cfg_o  = '{period: per_q, phase: ph_q, expo: {clkf_q, mode_q}};
endmodule

// File: rtl/pwm_timer_stage.sv
// Module: active-settings stage. Follows the programmed settings while idle,
// and while running reloads them only at a period boundary with sync low.
module pwm_timer_stage
    import pwm_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     sync,
    input  logic     boundary,
    input  pwm_cfg_t cfg_in,
    output pwm_cfg_t cfg_act
);
    // Load the active set when idle or at an unsynced period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cfg_act <= '0;
        else if (!run || (boundary && !sync)) cfg_act <= cfg_in;
    end
endmodule

// File: rtl/pwm_timer_prescaler.sv
// Module: power-of-two prescaler. Emits a one-cycle tick every 2^expo clocks
// while running; held at zero when idle so every run starts aligned.
// Exponents above MAX_EXP are clamped.
module pwm_timer_prescaler #(
    parameter int EXP_W   = 5,
    parameter int MAX_EXP = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);
    localparam int SH_W = MAX_EXP + 1;

    logic [MAX_EXP-1:0] cnt_q;
    logic [EXP_W-1:0]   expo_c;
    logic [SH_W-1:0]    span;
    logic [MAX_EXP-1:0] limit;

    // Clamp the exponent and derive the terminal count.
    always_comb begin
        expo_c = (expo > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : expo;
        span   = SH_W'(1) << expo_c;
        limit  = MAX_EXP'(span - SH_W'(1));
    end

    assign tick = run && (cnt_q == limit);

    // Count input clocks, wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + MAX_EXP'(1);
    end
endmodule

// File: rtl/pwm_timer_counter.sv
// Module: period position counter and output compare. Advances on each
// prescaled tick, flags the last tick of a period, drives high while the
// position is below the phase count.
module pwm_timer_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] pos,
    output logic             boundary,
    output logic             pwm
);
    assign boundary = run && tick && (pos == period - CNT_W'(1));
    assign pwm      = run && (pos < phase);

    // Step the position once per tick, restart at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pos <= '0;
        else if (boundary)  pos <= '0;
        else if (tick)      pos <= pos + CNT_W'(1);
    end
endmodule

// File: rtl/pwm_timer_top.sv
// Module: top of the single-channel PWM timer. Ties the register file,
// active-settings stage, prescaler and period counter together.
// Assumes a synchronous active-low reset and a single clock.
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);
    logic             en_w, sync_w, run_w, tick_w, boundary_w;
    logic [CNT_W-1:0] pos_w;
    pwm_cfg_t         prog_cfg, act_cfg;

    pwm_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .en_o(en_w), .sync_o(sync_w),
        .run_o(run_w), .cfg_o(prog_cfg)
    );

    pwm_timer_stage u_stage (
        .clk(clk), .rst_n(rst_n), .run(run_w), .sync(sync_w),
        .boundary(boundary_w), .cfg_in(prog_cfg), .cfg_act(act_cfg)
    );

    pwm_timer_prescaler #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_w), .expo(act_cfg.expo),
        .tick(tick_w)
    );

    pwm_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w),
        .period(act_cfg.period), .phase(act_cfg.phase),
        .pos(pos_w), .boundary(boundary_w), .pwm(pwm_out)
    );
endmodule

// File: rtl/pwm_timer_chk.sv
// Module: assertion checker for pwm_timer_top, attached by bind below.
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              sync,
    input logic              run,
    input logic [CNT_W-1:0]  prog_period,
    input logic [CNT_W-1:0]  prog_phase,
    input logic [CNT_W-1:0]  pos,
    input pwm_cfg_t          act,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              pwm_out
);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << SYNC_BIT) |
        (DATA_W'(1) << MODE_BIT) | (DATA_W'((1 << CLKF_W) - 1) << CLKF_LSB);

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out); // R8
    AST_ZERO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_period == '0 || prog_phase == '0) |=> !pwm_out); // R7
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> pos == '0); // R5
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> pos < act.period); // R5
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && run) |=> $stable(act)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(CTRL_OFF)) |-> (rdata & ~CTRL_MASK) == '0); // R2
endmodule

bind pwm_timer_top pwm_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .sync(sync_w), .run(run_w),
    .prog_period(prog_cfg.period), .prog_phase(prog_cfg.phase),
    .pos(pos_w), .act(act_cfg), .addr(addr), .rdata(rdata),
    .pwm_out(pwm_out)
);

// File: tb/pwm_timer_tb.sv
// Bench: directed corners plus seeded random settings, waveform measured.
module pwm_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;
    int          n_checks = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    pwm_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] ctrl_word(input bit en, input bit sy, input int e);
        return 32'(en) | (32'(sy) << 11) | (32'(e & 1) << 15) | (32'((e >> 1) & 15) << 16);
    endfunction
    function automatic logic [31:0] cnt_word(input int per, input int ph);
        return (32'(per & 1023) << 16) | 32'(ph & 1023);
    endfunction
    function automatic int exp_high(input int per, input int ph, input int e);
        return ((ph >= per) ? per : ph) << e;
    endfunction
    function automatic int exp_low(input int per, input int ph, input int e);
        return (ph >= per) ? 0 : ((per - ph) << e);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // Find a rising edge of the output, then count high and low clocks.
    task automatic measure(output int hi, output int lo);
        int g;
        hi = -1; lo = -1;
        g = 0;
        @(negedge clk);
        while (pwm_out && g < 20000) begin @(negedge clk); g++; end
        while (!pwm_out && g < 20000) begin @(negedge clk); g++; end
        if (g >= 20000) return;
        hi = 0;
        while (pwm_out && hi < 20000) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_out && lo < 20000) begin lo++; @(negedge clk); end
    endtask

    task automatic run_cfg(input int per, input int ph, input int e);
        wr(4'h0, 32'h0);
        wr(4'h4, cnt_word(per, ph));
        wr(4'h0, ctrl_word(1, 0, e));
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int hi, lo, highs, per, ph, e;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check(4'h0, 32'h0, "R1 ctrl");
        rd_check(4'h4, 32'h0, "R1 cnt");
        check("R1 out", pwm_out, 0);

        // R2/R3: layout and reserved bits
        wr(4'h0, 32'hFFFF_F7FE);
        rd_check(4'h0, 32'h000F_8000, "R2 mask");
        wr(4'h4, 32'hFFFF_FFFF);
        rd_check(4'h4, 32'h03FF_03FF, "R3 mask");
        wr(4'h0, 32'h0);
        rd_check(4'h0, 32'h0, "R2 clear");

        // R10: other address ignored
        wr(4'h8, 32'hFFFF_FFFF);
        rd_check(4'h8, 32'h0, "R10 read");
        rd_check(4'h4, 32'h03FF_03FF, "R10 cnt kept");
        rd_check(4'h0, 32'h0, "R10 ctrl kept");

        // R5 directed: exponent 5 uses both fields
        run_cfg(3, 1, 5);
        rd_check(4'h0, 32'h0002_8001, "R2 readback");
        measure(hi, lo);
        check("R4 high e5", hi, 32);
        check("R5 low e5", lo, 64);

        // R4/R5 random settings
        for (int k = 0; k < 8; k++) begin
            e   = int'($urandom_range(3, 0));
            per = int'($urandom_range(16, 2));
            ph  = int'($urandom_range(per - 1, 1));
            run_cfg(per, ph, e);
            measure(hi, lo);
            check("R5 high", hi, exp_high(per, ph, e));
            check("R4 low", lo, exp_low(per, ph, e));
        end

        // R6: phase >= period stays high
        run_cfg(3, 5, 1);
        repeat (4) @(negedge clk);
        count_high(60, highs);
        check("R6 ph>per", highs, 60);
        run_cfg(4, 4, 0);
        repeat (4) @(negedge clk);
        count_high(40, highs);
        check("R6 ph=per", highs, 40);

        // R7: zero counts refused
        run_cfg(0, 5, 0);
        count_high(100, highs);
        check("R7 zero period", highs, 0);
        run_cfg(5, 0, 0);
        count_high(100, highs);
        check("R7 zero phase", highs, 0);

        // R8: disable stops, re-enable starts fresh
        run_cfg(8, 4, 0);
        measure(hi, lo);
        wr(4'h0, ctrl_word(0, 0, 0));
        @(negedge clk);
        count_high(40, highs);
        check("R8 disabled low", highs, 0);
        wr(4'h0, ctrl_word(1, 0, 0));
        check("R8 not yet", pwm_out, 0);
        highs = 0;
        @(negedge clk);
        while (pwm_out && highs < 50) begin highs++; @(negedge clk); end
        check("R8 fresh high", highs, 4);

        // R9: staged update under sync
        run_cfg(10, 3, 0);
        wr(4'h0, ctrl_word(1, 1, 0));
        wr(4'h4, cnt_word(6, 2));
        wr(4'h0, ctrl_word(1, 1, 1));
        rd_check(4'h4, cnt_word(6, 2), "R9 read new");
        measure(hi, lo);
        check("R9 held high", hi, 3);
        check("R9 held low", lo, 7);
        wr(4'h0, ctrl_word(1, 0, 1));
        measure(hi, lo);
        check("R9 new high", hi, 4);
        check("R9 new low", lo, 8);

        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule